// File: doc/BRIEF.md
# Single-Error-Correcting RAM with Built-In Self Test

This block puts a single-port memory behind an error-correcting code. Every word written is stored with five Hamming check bits and one overall parity bit. On every read the stored word is decoded. A single flipped bit, in any of the 22 stored positions, is repaired before the data leaves the block. Two flipped bits are reported as uncorrectable. Each read result carries one flag for a corrected upset and one for an uncorrectable upset.

A self test sequencer can take over the memory. It is started by a pulse on a dedicated pin or by a one-cycle strobe from the slow-control register logic. It fills the whole array with a checkerboard pattern and reads every word back through the decoder. It then writes the complement of that pattern and reads it back. Busy, done and fail are visible to the control logic throughout.

A test mask input is XORed into the codeword on every write. It lets a bench or an in-system test plant upsets on purpose and exercise the encoder and decoder.

Top module: `secded_ram_bist`

## Requirements
- R1: A word written with `inj_mask` at zero reads back unchanged, with `err_corr` and `err_uncorr` both low.
- R2: A read accepted on a clock edge raises `rd_valid` for exactly the following cycle, and `rd_data` and the flags are meaningful only in that cycle. Back-to-back reads give back-to-back results.
- R3: If the stored codeword differs from the encoded word in exactly one of its 22 bit positions (planted through `inj_mask`), the read returns the original data with `err_corr` high and `err_uncorr` low.
- R4: If the stored codeword differs in exactly two bit positions, the read raises `err_uncorr` and keeps `err_corr` low.
- R5: When `wr_en` and `rd_en` are high in the same cycle, the write is performed and the read is dropped, so no `rd_valid` follows.
- R6: A one-cycle high on `bist_pin` or on `cfg_start` while the test is idle raises `bist_busy` from the next cycle. A start while busy has no effect.
- R7: A test run keeps `bist_busy` high for exactly 4*DEPTH+1 cycles. Afterwards each even address holds 16'hAAAA and each odd address holds 16'h5555.
- R8: When a run ends, `bist_done` rises in the same cycle that `bist_busy` falls. On a clean memory `bist_fail` is low. Both flags hold until the next start, which clears them.
- R9: If any read-back during the run shows a data mismatch or either error flag, `bist_fail` is high at the end of the run. This happens, for example, when a nonzero `inj_mask` is held during the run.
- R10: While `bist_busy` is high, normal writes and reads are ignored: no `rd_valid` appears and memory contents are not changed by them.
- R11: After reset, `bist_busy`, `bist_done`, `bist_fail`, `rd_valid`, `err_corr` and `err_uncorr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word address for the request |
| wr_data | input | 16 | Write data |
| inj_mask | input | 22 | Bits XORed into the stored codeword on every write |
| bist_pin | input | 1 | Self test start pulse from the pin |
| cfg_start | input | 1 | Self test start strobe from the control registers |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Corrected read data |
| err_corr | output | 1 | Single-bit upset corrected on this read |
| err_uncorr | output | 1 | Uncorrectable upset on this read |
| bist_busy | output | 1 | Self test running |
| bist_done | output | 1 | Self test finished |
| bist_fail | output | 1 | Self test saw an error |

## Verification
The bench plants a single upset in every one of the 22 codeword positions, including the check bits and the overall parity bit. A decoder with a wrong syndrome map would repair the wrong bit and return bad data. Double upsets are aimed at a decoder that takes the uncorrectable case as correctable and raises `err_corr`. During a run the bench fires a second start and also drives writes and reads. A sequencer that restarts would stretch the busy window, and leaky request gating would corrupt the final pattern or produce a stray `rd_valid`. A run with a mask held active must end with fail set. That catches a sequencer that drops the comparison of the final read.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DW = 16;
  localparam int PW = 5;
  localparam int CW = DW + PW + 1;

  typedef struct packed {
    logic [DW-1:0] data;
    logic          corr;
    logic          uncorr;
  } dec_t;

  function automatic bit is_pow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Position 0 is overall parity, powers of two hold check bits,
  // data fills the remaining positions LSB first.
  function automatic logic [CW-1:0] ecc_encode(logic [DW-1:0] d);
    logic [CW-1:0] c;
    int j;
    c = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < PW; k++) begin
      logic x;
      x = 1'b0;
      for (int p = 1; p < CW; p++) if (p[k]) x = x ^ c[p];
      c[1 << k] = x;
    end
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic dec_t ecc_decode(logic [CW-1:0] c);
    dec_t r;
    logic [PW-1:0] s;
    logic [CW-1:0] f;
    int j;
    s = '0;
    for (int k = 0; k < PW; k++)
      for (int p = 1; p < CW; p++) if (p[k]) s[k] = s[k] ^ c[p];
    f = c;
    r.corr = 1'b0;
    r.uncorr = 1'b0;
    if (^c) begin
      if (int'(s) < CW) begin
        f[s] = ~f[s];
        r.corr = 1'b1;
      end else begin
        r.uncorr = 1'b1;
      end
    end else if (s != '0) begin
      r.uncorr = 1'b1;
    end
    r.data = '0;
    j = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        r.data[j] = f[p];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] bist_pat(logic lsb, logic phase);
    return (lsb ^ phase) ? {(DW/2){2'b10}} : {(DW/2){2'b01}};
  endfunction
endpackage

// File: rtl/secded_array.sv
module secded_array #(
  parameter int AW = 5,
  parameter int W  = 22
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
(
  input  logic [CW-1:0] code,
  output logic [DW-1:0] data,
  output logic          corr,
  output logic          uncorr
);
  dec_t res;
  always_comb res = ecc_decode(code);
  assign data   = res.data;
  assign corr   = res.corr;
  assign uncorr = res.uncorr;
endmodule

// File: rtl/secded_bist.sv
module secded_bist
  import secded_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_corr,
  input  logic          rd_uncorr,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          we,
  output logic          re,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  localparam int DEPTH   = 1 << AW;
  localparam int RUN_LEN = 4 * DEPTH + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [2:0] {B_IDLE, B_WR0, B_RD0, B_WR1, B_RD1, B_END} bst_t;
  bst_t          st;
  logic [AW-1:0] cnt;
  logic          chk_q;
  logic [DW-1:0] exp_q;
  logic          mismatch;
  logic [AW+2:0] run_cnt;

  assign busy     = (st != B_IDLE);
  assign we       = (st == B_WR0) || (st == B_WR1);
  assign re       = (st == B_RD0) || (st == B_RD1);
  assign addr     = cnt;
  assign wdata    = bist_pat(cnt[0], st == B_WR1);
  assign mismatch = chk_q && ((rd_data != exp_q) || rd_corr || rd_uncorr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= B_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
      fail  <= 1'b0;
      chk_q <= 1'b0;
      exp_q <= '0;
    end else begin
      chk_q <= 1'b0;
      if (mismatch) fail <= 1'b1;
      case (st)
        B_IDLE: if (start) begin
          st   <= B_WR0;
          cnt  <= '0;
          done <= 1'b0;
          fail <= 1'b0;
        end
        B_WR0, B_WR1: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= (st == B_WR0) ? B_RD0 : B_RD1;
        end
        B_RD0, B_RD1: begin
          chk_q <= 1'b1;
          exp_q <= bist_pat(cnt[0], st == B_RD1);
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) st <= (st == B_RD0) ? B_WR1 : B_END;
        end
        B_END: begin
          done <= 1'b1;
          st   <= B_IDLE;
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  // Run-length counter kept for the bound check below.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + 1'b1;
    else run_cnt <= '0;
  end

  a_r7_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(run_cnt) < RUN_LEN));
  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !fail));
  a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> fail);
endmodule

// File: rtl/secded_ram_bist.sv
module secded_ram_bist
  import secded_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CW-1:0]     inj_mask,
  input  logic              bist_pin,
  input  logic              cfg_start,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic              err_corr,
  output logic              err_uncorr,
  output logic              bist_busy,
  output logic              bist_done,
  output logic              bist_fail
);
  logic              b_we, b_re;
  logic [ADDR_W-1:0] b_addr;
  logic [DW-1:0]     b_wdata;
  logic              acc_wr, acc_rd;
  logic              m_we, m_re;
  logic [ADDR_W-1:0] m_addr;
  logic [CW-1:0]     m_wcode, m_rcode;
  logic [DW-1:0]     d_data;
  logic              d_corr, d_uncorr;
  logic              rvalid_q;

  assign acc_wr  = wr_en && !bist_busy;
  assign acc_rd  = rd_en && !wr_en && !bist_busy;
  assign m_we    = bist_busy ? b_we : acc_wr;
  assign m_re    = bist_busy ? b_re : acc_rd;
  assign m_addr  = bist_busy ? b_addr : addr;
  assign m_wcode = ecc_encode(bist_busy ? b_wdata : wr_data) ^ inj_mask;

  secded_array #(.AW(ADDR_W), .W(CW)) u_array (
    .clk(clk), .we(m_we), .re(m_re), .addr(m_addr),
    .wdata(m_wcode), .rdata(m_rcode)
  );

  secded_dec u_dec (
    .code(m_rcode), .data(d_data), .corr(d_corr), .uncorr(d_uncorr)
  );

  secded_bist #(.AW(ADDR_W)) u_bist (
    .clk(clk), .rst_n(rst_n), .start(bist_pin || cfg_start),
    .rd_data(d_data), .rd_corr(d_corr), .rd_uncorr(d_uncorr),
    .busy(bist_busy), .done(bist_done), .fail(bist_fail),
    .we(b_we), .re(b_re), .addr(b_addr), .wdata(b_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else rvalid_q <= acc_rd;
  end

  assign rd_valid   = rvalid_q;
  assign rd_data    = rvalid_q ? d_data : '0;
  assign err_corr   = rvalid_q && d_corr;
  assign err_uncorr = rvalid_q && d_uncorr;

  a_r3_flag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr || err_uncorr) |-> rd_valid);
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr && err_uncorr));
  a_r5_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> !rd_valid);
  a_r10_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bist_busy) |-> !rd_valid);
endmodule

// File: tb/secded_ram_bist_bench.sv
module secded_ram_bist_bench;
  localparam int AW = 5;
  localparam int DEPTH = 1 << AW;
  localparam int RUN = 4 * DEPTH + 1;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, bist_pin = 0, cfg_start = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic [21:0] inj_mask = '0;
  logic rd_valid, err_corr, err_uncorr, bist_busy, bist_done, bist_fail;
  logic [15:0] rd_data;

  int checks = 0, fails = 0;
  logic [18:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  secded_ram_bist #(.ADDR_W(AW)) u_secded_ram_bist (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .inj_mask(inj_mask), .bist_pin(bist_pin),
    .cfg_start(cfg_start), .rd_valid(rd_valid), .rd_data(rd_data),
    .err_corr(err_corr), .err_uncorr(err_uncorr), .bist_busy(bist_busy),
    .bist_done(bist_done), .bist_fail(bist_fail)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare each read result with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2/R5/R10 unexpected rd_valid", 1, 0);
      end else begin
        logic [18:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[18]) chk(rd_data == e[15:0], {t, " data"}, rd_data, e[15:0]);
        chk(err_corr == e[16], {t, " corr"}, err_corr, e[16]);
        chk(err_uncorr == e[17], {t, " uncorr"}, err_uncorr, e[17]);
      end
    end
  end

  task automatic wr(int a, logic [15:0] d, logic [21:0] m);
    wr_en = 1; addr = AW'(a); wr_data = d; inj_mask = m;
    @(posedge clk); #1;
    wr_en = 0; inj_mask = '0;
  endtask

  task automatic rd(int a, logic [15:0] d, bit c, bit u, bit chkd, string t);
    rd_en = 1; addr = AW'(a);
    exp_q.push_back({chkd, u, c, d});
    tag_q.push_back(t);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Runs the self test; optionally pokes requests and a restart while busy.
  task automatic run_bist(bit via_pin, logic [21:0] m, bit poke, output int len, output int stray);
    inj_mask = m;
    if (via_pin) bist_pin = 1; else cfg_start = 1;
    @(posedge clk); #1;
    bist_pin = 0; cfg_start = 0;
    len = 0; stray = 0;
    for (int cyc = 0; cyc < RUN + 20; cyc++) begin
      if (poke && cyc == 10) begin wr_en = 1; addr = 5; wr_data = 16'h1234; end
      if (poke && cyc == 11) wr_en = 0;
      if (poke && cyc == 20) begin rd_en = 1; addr = 6; end
      if (poke && cyc == 21) rd_en = 0;
      if (poke && cyc == 50) bist_pin = 1;
      if (poke && cyc == 51) bist_pin = 0;
      @(negedge clk);
      if (bist_busy) len++;
      if (rd_valid) stray++;
      if (!bist_busy) break;
      @(posedge clk); #1;
    end
    inj_mask = '0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int len, stray;
    idle(2);
    @(negedge clk);
    chk(!bist_busy && !bist_done && !bist_fail, "R11 status in reset", {bist_busy, bist_done, bist_fail}, 0);
    chk(!rd_valid && !err_corr && !err_uncorr, "R11 read outputs in reset", {rd_valid, err_corr, err_uncorr}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    idle(1);

    // R1 / R2: clean round trips, back-to-back reads
    wr(0, 16'h0000, 0); wr(1, 16'hFFFF, 0); wr(2, 16'hA5C3, 0); wr(3, 16'h8001, 0);
    rd(0, 16'h0000, 0, 0, 1, "R1 zero"); rd(1, 16'hFFFF, 0, 0, 1, "R1 ones");
    rd(2, 16'hA5C3, 0, 0, 1, "R2 back-to-back"); rd(3, 16'h8001, 0, 0, 1, "R2 back-to-back");
    idle(3);

    // R3: single upset at each of the 22 codeword positions
    for (int k = 0; k < 22; k++) begin
      logic [15:0] d;
      d = 16'h3C5A ^ 16'(k * 16'h0713);
      wr(k, d, 22'(1) << k);
      rd(k, d, 1, 0, 1, $sformatf("R3 bit%0d", k));
    end
    idle(3);

    // R4: double upsets
    wr(24, 16'h1111, 22'h000003); rd(24, 0, 0, 1, 0, "R4 bits0_1");
    wr(25, 16'hBEEF, 22'h200010); rd(25, 0, 0, 1, 0, "R4 bits4_21");
    wr(26, 16'h7E7E, 22'h000840); rd(26, 0, 0, 1, 0, "R4 bits6_11");
    idle(3);

    // R5: write wins over read in same cycle
    wr(27, 16'h0F0F, 0);
    rd_en = 1; wr(27, 16'hCAFE, 0); rd_en = 0;
    idle(2);
    rd(27, 16'hCAFE, 0, 0, 1, "R5 write performed");
    idle(3);
    chk(exp_q.size() == 0, "R5 pending reads", exp_q.size(), 0);

    // R6/R7/R8/R10: run from control strobe, with requests and a restart during it
    run_bist(0, 0, 1, len, stray);
    chk(len == RUN, "R7 busy length with restart attempt (R6)", len, RUN);
    chk(stray == 0, "R10 no rd_valid while busy", stray, 0);
    chk(bist_done && !bist_fail, "R8 done clean", {bist_done, bist_fail}, 2);
    for (int a = 0; a < DEPTH; a++)
      rd(a, a[0] ? 16'h5555 : 16'hAAAA, 0, 0, 1, $sformatf("R7/R10 final pattern a%0d", a));
    idle(4);
    chk(bist_done && !bist_fail, "R8 flags held", {bist_done, bist_fail}, 2);

    // R9: upsets during the run from the pin
    run_bist(1, 22'h000008, 0, len, stray);
    chk(len == RUN, "R6 pin start busy length", len, RUN);
    chk(bist_done && bist_fail, "R9 fail on single upset", {bist_done, bist_fail}, 3);
    run_bist(1, 22'h000011, 0, len, stray);
    chk(bist_done && bist_fail, "R9 fail on double upset", {bist_done, bist_fail}, 3);
    idle(5);
    chk(bist_fail, "R8 fail held", bist_fail, 1);
    run_bist(1, 0, 0, len, stray);
    chk(bist_done && !bist_fail, "R8 restart clears fail", {bist_done, bist_fail}, 2);

    idle(3);
    chk(exp_q.size() == 0, "R2 all reads answered", exp_q.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule